// File: doc/BRIEF.md
# Synchronous Burst Read Timing Sequencer

This block produces the cycle timing of a synchronous burst read for a clocked memory port. A chip-enable and an address-valid strobe open a burst and latch a starting word address. The block then counts an initial latency, chosen by a 4-bit wait code, before the first word. It drives a ready pin with a programmable polarity. The pin can either lead each data word by one clock or line up with it.

The block then steps the current word address once per clock. A burst is 8, 16 or 32 words and can run linearly or wrap inside its aligned block. A continuous burst runs until chip-enable is dropped.

The memory array is outside the block. The surrounding logic uses `dataValid` and `wordAddr` to fetch and present each word. The burst length and wrap choice are captured when the burst starts. The ready polarity and lead are read live.

Top module: `sync_burst_sequencer`

## Requirements
- R1: With the start address latched at clock edge L and a latency of N edges, `dataValid` is first high in the cycle that ends at edge L+N. It is low in every cycle before that.
- R2: The wait code is the concatenation {`waitCodeHi`, `waitCodeLo`}. Codes 0000 to 0101 give N = code + 2, which is 2 to 7. Code 1000 gives N = 8 and code 1001 gives N = 9.
- R3: `burstLenSel` selects the burst length: 010 gives 8 words, 011 gives 16 words, 100 gives 32 words and 000 gives a continuous burst. A fixed burst holds `dataValid` high for exactly that many consecutive cycles, then drops it.
- R4: When `wrapEn` is 1 on a fixed burst, word k has address (start & ~(BL-1)) | ((start+k) & (BL-1)), so it stays inside its aligned block.
- R5: When `wrapEn` is 0, or the burst is continuous, word k has address start+k modulo 2^ADDR_W. The address rolls over at the top of the space.
- R6: When `rdyWithData` is 1, ready is active exactly in the `dataValid` cycles. When it is 0, ready is active in each cycle that is followed by a data cycle, so it leads every word by one clock.
- R7: `rdy` equals `rdyActiveHigh` when ready is active and its inverse when ready is inactive.
- R8: In any cycle where `chipEn` is 0, `dataValid` is 0 and `rdy` is inactive. The burst is abandoned and nothing restarts without a new `addrValid`.
- R9: Wait codes outside the R2 list act as N = 9. Length codes outside the R3 list act as continuous.
- R10: After reset, with `chipEn` low, `dataValid` is 0 and `rdy` is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| addrValid | input | 1 | Start strobe; with chipEn high it latches the start address |
| chipEn | input | 1 | Chip enable, active high; low aborts the burst |
| startAddr | input | ADDR_W | Starting word address |
| waitCodeLo | input | 3 | Low three bits of the wait code |
| waitCodeHi | input | 1 | High bit of the wait code |
| burstLenSel | input | 3 | Burst length code |
| wrapEn | input | 1 | 1 = wrap inside the aligned block, 0 = linear |
| rdyWithData | input | 1 | 1 = ready in the data cycle, 0 = ready one clock earlier |
| rdyActiveHigh | input | 1 | Ready polarity, 1 = active high |
| rdy | output | 1 | Ready/wait indication |
| dataValid | output | 1 | High in each cycle that carries a burst word |
| wordAddr | output | ADDR_W | Address of the current burst word |

## Verification
A chip-enable drop can land in the same cycle as the last word of a fixed burst, or in the cycle where the leading ready has already been predicted for the next word. The bench opens fixed bursts and drops `chipEn` exactly on the final data cycle. It also drops `chipEn` in the middle of the latency count and in random places. In the abort cycle and every cycle after it, `dataValid` must be low and `rdy` must sit at its inactive level. Up to the abort, the outputs must match the uninterrupted burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DATA = 2'd2
  } seqState_t;

  // Strobes from control to the address datapath
  typedef struct packed {
    logic load;   // capture start address and burst shape
    logic step;   // advance to the next word
  } seqStrobe_t;

  // Number of clock edges from address latch to the first data word
  function automatic logic [3:0] latencyEdges(input logic hi, input logic [2:0] lo);
    if (!hi && lo <= 3'd5) return {1'b0, lo} + 4'd2;
    else if (hi && lo == 3'd0) return 4'd8;
    else return 4'd9;
  endfunction

  // Burst length in words; zero means continuous
  function automatic logic [5:0] burstWords(input logic [2:0] sel);
    case (sel)
      3'b010:  return 6'd8;
      3'b011:  return 6'd16;
      3'b100:  return 6'd32;
      default: return 6'd0;
    endcase
  endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrValid,
  input  logic       chipEn,
  input  logic       waitCodeHi,
  input  logic [2:0] waitCodeLo,
  input  logic       lastWord,
  input  logic       penultWord,
  output seqStrobe_t strobe,
  output logic       inData,
  output logic       rdyEarly
);

  seqState_t  state, nextState;
  logic [3:0] latCnt, nextLat;
  logic [3:0] latN;
  logic       nextEarly;

  assign latN = latencyEdges(waitCodeHi, waitCodeLo);

  always_comb begin
    nextState = state;
    nextLat   = latCnt;
    nextEarly = 1'b0;
    strobe    = '0;
    if (chipEn && addrValid) begin
      strobe.load = 1'b1;
      nextState   = ST_WAIT;
      nextLat     = latN - 4'd1;
      nextEarly   = (latN == 4'd2);
    end else if (!chipEn) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_WAIT: begin
          if (latCnt == 4'd1) begin
            nextState = ST_DATA;
            nextEarly = 1'b1;
          end else begin
            nextLat   = latCnt - 4'd1;
            nextEarly = (latCnt == 4'd2);
          end
        end
        ST_DATA: begin
          if (lastWord) begin
            nextState = ST_IDLE;
          end else begin
            strobe.step = 1'b1;
            nextEarly   = !penultWord;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      latCnt   <= '0;
      rdyEarly <= 1'b0;
    end else begin
      state    <= nextState;
      latCnt   <= nextLat;
      rdyEarly <= nextEarly;
    end
  end

  assign inData = (state == ST_DATA);

  // R8: a dropped chip enable always leaves the sequencer idle
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn |=> state == ST_IDLE);

  // R6: an early ready is always followed by a data cycle while the burst continues
  p_lead_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdyEarly && chipEn && !addrValid) |=> state == ST_DATA);

  // R3: the last word of a fixed burst ends the data phase
  p_burst_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && lastWord && chipEn && !addrValid) |=> state == ST_IDLE);

  // R1: a start strobe always enters the latency count
  p_load_wait_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (state == ST_WAIT && latCnt != 4'd0));

endmodule

// File: rtl/burst_addr.sv
module burst_addr
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [2:0]        burstLenSel,
  input  logic              wrapEn,
  output logic [ADDR_W-1:0] wordAddr,
  output logic              lastWord,
  output logic              penultWord
);

  localparam int CNT_W = 6;

  logic [CNT_W-1:0]  remCnt;
  logic              contReg;
  logic              wrapReg;
  logic [ADDR_W-1:0] maskReg;
  logic [CNT_W-1:0]  loadWords;
  logic [ADDR_W-1:0] loadMask;
  logic [ADDR_W-1:0] incAddr;
  logic [ADDR_W-1:0] nextAddr;

  assign loadWords = burstWords(burstLenSel);
  assign loadMask  = ADDR_W'(loadWords - CNT_W'(1));
  assign incAddr   = wordAddr + ADDR_W'(1);
  assign nextAddr  = wrapReg ? ((wordAddr & ~maskReg) | (incAddr & maskReg)) : incAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordAddr <= '0;
      remCnt   <= '0;
      contReg  <= 1'b0;
      wrapReg  <= 1'b0;
      maskReg  <= '0;
    end else if (strobe.load) begin
      wordAddr <= startAddr;
      remCnt   <= loadWords;
      contReg  <= (loadWords == '0);
      wrapReg  <= wrapEn && (loadWords != '0);
      maskReg  <= loadMask;
    end else if (strobe.step) begin
      wordAddr <= nextAddr;
      if (!contReg) remCnt <= remCnt - CNT_W'(1);
    end
  end

  assign lastWord   = !contReg && (remCnt == CNT_W'(1));
  assign penultWord = !contReg && (remCnt == CNT_W'(2));

  // R5: a linear step adds one to the address
  p_linear_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !wrapReg) |=> wordAddr == $past(wordAddr) + ADDR_W'(1));

  // R4: a wrapping step never leaves the aligned block
  p_wrap_block_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && wrapReg) |=> (wordAddr & ~maskReg) == ($past(wordAddr) & ~maskReg));

  // R3: a fixed burst counts down one word per step
  p_count_down_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !contReg) |=> remCnt == $past(remCnt) - CNT_W'(1));

endmodule

// File: rtl/sync_burst_sequencer.sv
module sync_burst_sequencer
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrValid,
  input  logic              chipEn,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [2:0]        waitCodeLo,
  input  logic              waitCodeHi,
  input  logic [2:0]        burstLenSel,
  input  logic              wrapEn,
  input  logic              rdyWithData,
  input  logic              rdyActiveHigh,
  output logic              rdy,
  output logic              dataValid,
  output logic [ADDR_W-1:0] wordAddr
);

  seqStrobe_t strobe;
  logic       inData;
  logic       rdyEarly;
  logic       lastWord;
  logic       penultWord;
  logic       rdyAct;

  burst_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .addrValid  (addrValid),
    .chipEn     (chipEn),
    .waitCodeHi (waitCodeHi),
    .waitCodeLo (waitCodeLo),
    .lastWord   (lastWord),
    .penultWord (penultWord),
    .strobe     (strobe),
    .inData     (inData),
    .rdyEarly   (rdyEarly)
  );

  burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .startAddr   (startAddr),
    .burstLenSel (burstLenSel),
    .wrapEn      (wrapEn),
    .wordAddr    (wordAddr),
    .lastWord    (lastWord),
    .penultWord  (penultWord)
  );

  assign dataValid = inData && chipEn;
  assign rdyAct    = chipEn && (rdyWithData ? inData : rdyEarly);
  assign rdy       = rdyAct ? rdyActiveHigh : !rdyActiveHigh;

endmodule

// File: tb/sync_burst_sequencer_tb.sv
module sync_burst_sequencer_tb;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          addrValid = 1'b0;
  logic          chipEn = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [2:0]    waitCodeLo = '0;
  logic          waitCodeHi = 1'b0;
  logic [2:0]    burstLenSel = '0;
  logic          wrapEn = 1'b0;
  logic          rdyWithData = 1'b1;
  logic          rdyActiveHigh = 1'b1;
  logic          rdy;
  logic          dataValid;
  logic [AW-1:0] wordAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sync_burst_sequencer #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .chipEn(chipEn),
    .startAddr(startAddr), .waitCodeLo(waitCodeLo), .waitCodeHi(waitCodeHi),
    .burstLenSel(burstLenSel), .wrapEn(wrapEn), .rdyWithData(rdyWithData),
    .rdyActiveHigh(rdyActiveHigh), .rdy(rdy), .dataValid(dataValid),
    .wordAddr(wordAddr)
  );

  function automatic int expLatency(input logic hi, input logic [2:0] lo);
    if (!hi && lo <= 3'd5) return int'(lo) + 2;
    if (hi && lo == 3'd0) return 8;
    return 9;
  endfunction

  function automatic int expWords(input logic [2:0] sel);
    case (sel)
      3'b010: return 8;
      3'b011: return 16;
      3'b100: return 32;
      default: return 0;
    endcase
  endfunction

  function automatic bit dvPlan(input int j, input int n, input int bl);
    return (j >= n - 1) && (bl == 0 || j < n - 1 + bl);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic runBurst(input logic [AW-1:0] st, input logic hi, input logic [2:0] lo,
                          input logic [2:0] lenSel, input logic wr, input logic withData,
                          input logic pol, input int abortAt, input int span, input string latTag);
    int n;
    int bl;
    n  = expLatency(hi, lo);
    bl = expWords(lenSel);
    @(negedge clk);
    startAddr = st; waitCodeHi = hi; waitCodeLo = lo; burstLenSel = lenSel;
    wrapEn = wr; rdyWithData = withData; rdyActiveHigh = pol;
    addrValid = 1'b1; chipEn = 1'b1;
    @(negedge clk);
    addrValid = 1'b0;
    startAddr = ~st;
    for (int j = 0; j < span; j++) begin
      bit aborted;
      bit dvE;
      bit actE;
      logic rdyE;
      logic [AW-1:0] mask;
      logic [AW-1:0] addrE;
      if (j == abortAt) chipEn = 1'b0;
      #1;
      aborted = (abortAt >= 0) && (j >= abortAt);
      dvE  = aborted ? 1'b0 : dvPlan(j, n, bl);
      actE = aborted ? 1'b0 : (withData ? dvPlan(j, n, bl) : dvPlan(j + 1, n, bl));
      rdyE = actE ? pol : !pol;
      if (aborted)
        check(dataValid == 1'b0 && rdy == rdyE, "R8", {30'd0, dataValid, rdy}, {30'd0, 1'b0, rdyE});
      else begin
        check(dataValid == dvE, (j < n - 1 || j == n - 1) ? latTag : "R3", dataValid, dvE);
        check(rdy == rdyE, "R6 R7", rdy, rdyE);
      end
      if (dvE) begin
        mask = AW'(bl - 1);
        if (wr && bl != 0) addrE = (st & ~mask) | ((st + AW'(j - (n - 1))) & mask);
        else addrE = st + AW'(j - (n - 1));
        check(wordAddr == addrE, (wr && bl != 0) ? "R4" : "R5", 32'(wordAddr), 32'(addrE));
      end
      @(negedge clk);
    end
    chipEn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rdyActiveHigh = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(dataValid == 1'b0, "R10", dataValid, 0);
    check(rdy == 1'b0, "R10", rdy, 0);
    rdyActiveHigh = 1'b0;
    #1;
    check(rdy == 1'b1, "R10", rdy, 1);

    // Directed: shortest latency, leading ready, linear 8
    runBurst(24'h000005, 1'b0, 3'd0, 3'b010, 1'b0, 1'b0, 1'b1, -1, 12, "R2");
    // Latency code 1000 and 1001, wrapped 16 and 32
    runBurst(24'h00013B, 1'b1, 3'd0, 3'b011, 1'b1, 1'b1, 1'b1, -1, 26, "R2");
    runBurst(24'h7FFFFD, 1'b1, 3'd1, 3'b100, 1'b1, 1'b0, 1'b0, -1, 44, "R2");
    // Reserved wait codes act as nine edges
    runBurst(24'h000010, 1'b0, 3'd7, 3'b010, 1'b0, 1'b1, 1'b1, -1, 19, "R9");
    runBurst(24'h000020, 1'b1, 3'd7, 3'b010, 1'b1, 1'b0, 1'b1, -1, 19, "R9");
    // Reserved length code runs continuously, rolls over the address space
    runBurst(24'hFFFFFC, 1'b0, 3'd3, 3'b001, 1'b1, 1'b0, 1'b1, 24, 28, "R9");
    // Continuous burst across the top, with-data ready
    runBurst(24'hFFFFFE, 1'b0, 3'd1, 3'b000, 1'b0, 1'b1, 1'b0, 20, 24, "R1");
    // Abort during latency, and on the final data word
    runBurst(24'h000100, 1'b1, 3'd1, 3'b010, 1'b0, 1'b0, 1'b1, 3, 12, "R1");
    runBurst(24'h000207, 1'b0, 3'd2, 3'b010, 1'b1, 1'b0, 1'b1, 3 + 7, 14, "R1");
    runBurst(24'h000207, 1'b0, 3'd2, 3'b011, 1'b1, 1'b1, 1'b0, 3 + 15, 22, "R1");

    for (int i = 0; i < 40; i++) begin
      logic hi;
      logic [2:0] lo;
      logic [2:0] sel;
      int n;
      int bl;
      int span;
      int ab;
      hi  = 1'($urandom % 2);
      lo  = hi ? 3'($urandom % 2) : 3'($urandom % 6);
      case ($urandom % 4)
        0: sel = 3'b000;
        1: sel = 3'b010;
        2: sel = 3'b011;
        default: sel = 3'b100;
      endcase
      n  = expLatency(hi, lo);
      bl = expWords(sel);
      span = n - 1 + ((bl == 0) ? 20 : bl) + 2;
      if (bl == 0) ab = n - 1 + 20;
      else if ($urandom % 4 == 0) ab = int'($urandom % span);
      else ab = -1;
      runBurst(AW'($urandom), hi, lo, sel, 1'($urandom % 2), 1'($urandom % 2),
               1'($urandom % 2), ab, span, "R2");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule